// File: doc/BRIEF.md
# FIFO Level and Interrupt Status Unit

This block sits between a serial shift engine and a host register port. It holds two byte FIFOs of 128 entries, one per direction. The host fills the transmit FIFO and drains the receive FIFO. The shift engine does the opposite. The block keeps an occupancy count for each FIFO. It compares each count with a programmable trigger level, and the two directions use opposite comparisons. The results drive ready flags, DMA request lines and a single interrupt line.

Errors are recorded as sticky flags. These cover a push into a full FIFO and a pop from an empty one. Two external events are also latched: end of transfer and loss of chip select. Software clears these flags by writing ones. Each FIFO can be emptied by a command bit that never reads back as set. A stop-on-full input makes the block ask the shift engine to pause while the receive FIFO is full.

Register port select values:
- 0: interrupt enable.
- 1: status.
- 2: FIFO control.
- 3: occupancy, read-only.

Reads are combinational from `reg_sel`. Writes take effect at the clock edge where `reg_we` is high.

Top module: `fifo_irq_status`

## Requirements
- R1: Under reset the port reads as follows: status 0x0000_0022, FIFO control 0x0040_0001, enable 0, occupancy 0. `irq`, `rx_dreq` and `tx_dreq` are low.
- R2: Each FIFO returns bytes in the order they were pushed, and `*_rdata` shows the oldest byte. A push and a pop in the same cycle leave the count unchanged. The occupancy register carries the receive count in bits 7:0 and the transmit count in bits 23:16.
- R3: Status bit 0 (receive ready) is 1 when receive count >= control bits 7:0.
- R4: Status bit 4 (transmit ready) is 1 when transmit count <= control bits 23:16.
- R5: Status bits 1/2 (receive empty/full) and 5/6 (transmit empty/full) track counts of 0 and 128. A push into a full FIFO is dropped. Status bits 0–6 show the FIFO state of the previous cycle.
- R6: Bit 8 (receive) and bit 10 (transmit) set on a push while full. Bit 9 (receive) and bit 11 (transmit) set on a pop while empty, and that pop changes nothing else. These bits stay set until cleared.
- R7: Writing status clears each of bits 8–13 written as 1. Bits written as 0, and bits 0–7, are unaffected. An event in the same cycle as its clear wins.
- R8: `xfer_done` sets status bit 12, and `cs_inval` sets status bit 13.
- R9: Only enable bits in 0x3F77 are stored. `irq` is the OR of all status bits ANDed with their enable bits.
- R10: A control write with bit 15 empties the receive FIFO, and one with bit 31 empties the transmit FIFO. The other FIFO is untouched. Both bits read back 0, and the other control fields take the written value.
- R11: `rx_dreq` = control bit 8 AND receive ready. `tx_dreq` = control bit 24 AND transmit ready. Both use the current counts.
- R12: `shift_hold` is high exactly when `stop_en` is high and the receive FIFO holds 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| tx_push | input | 1 | Host pushes a transmit byte |
| tx_wdata | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Shift engine takes a transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shift engine pushes a received byte |
| rx_wdata | input | 8 | Received byte in |
| rx_pop | input | 1 | Host takes a received byte |
| rx_rdata | output | 8 | Oldest received byte |
| xfer_done | input | 1 | End-of-transfer event pulse |
| cs_inval | input | 1 | Chip-select-released event pulse |
| stop_en | input | 1 | Stop-on-full option |
| shift_hold | output | 1 | Pause request to the shift engine |
| irq | output | 1 | Interrupt |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The hardest states to reach are the FIFO boundaries. These are a count of exactly 128, with trigger levels at 0x7F, 0x80 and 0xFF, and an extra push or pop past either end. The stimulus gets there by filling both FIFOs byte by byte from a flushed state for each row of a trigger table. It then overruns and underruns each direction on purpose. A clear and an event are also driven in the same cycle, so that the set-wins rule is visible at the status register.

// File: rtl/fifo_irq_status.sv
module fifo_irq_status #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter logic [7:0] RX_TRIG_RST = 8'h01,
  parameter logic [7:0] TX_TRIG_RST = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  input  logic          xfer_done,
  input  logic          cs_inval,
  input  logic          stop_en,
  output logic          shift_hold,
  output logic          irq,
  output logic          tx_dreq,
  output logic          rx_dreq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [13:0] IEN_MASK = 14'h3F77;

  logic wr_ien, wr_sta, wr_ctl;
  assign wr_ien = reg_we && reg_sel == 2'd0;
  assign wr_sta = reg_we && reg_sel == 2'd1;
  assign wr_ctl = reg_we && reg_sel == 2'd2;

  logic [1:0]          push_i, pop_i, flush_i, full_w, empty_w;
  logic [1:0][DW-1:0]  wd_i, rd_w;
  logic [1:0][CW-1:0]  cnt_w;

  assign push_i  = {tx_push, rx_push};
  assign pop_i   = {tx_pop, rx_pop};
  assign wd_i    = {tx_wdata, rx_wdata};
  assign flush_i = {wr_ctl & reg_wdata[31], wr_ctl & reg_wdata[15]};

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic do_push, do_pop;

    assign do_push = push_i[g] & ~full_w[g];
    assign do_pop  = pop_i[g] & ~empty_w[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else if (flush_i[g]) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end

    always_ff @(posedge clk)
      if (do_push && !flush_i[g]) mem[wp] <= wd_i[g];

    assign cnt_w[g]   = cnt;
    assign full_w[g]  = cnt == CW'(DEPTH);
    assign empty_w[g] = cnt == '0;
    assign rd_w[g]    = empty_w[g] ? '0 : mem[rp];
  end

  assign rx_rdata = rd_w[0];
  assign tx_rdata = rd_w[1];

  logic [7:0] rx_trig_q, tx_trig_q;
  logic       rx_dma_q, tx_dma_q;
  logic [13:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig_q <= RX_TRIG_RST;
      tx_trig_q <= TX_TRIG_RST;
      rx_dma_q  <= 1'b0;
      tx_dma_q  <= 1'b0;
      ien_q     <= '0;
    end else begin
      if (wr_ctl) begin
        rx_trig_q <= reg_wdata[7:0];
        rx_dma_q  <= reg_wdata[8];
        tx_trig_q <= reg_wdata[23:16];
        tx_dma_q  <= reg_wdata[24];
      end
      if (wr_ien) ien_q <= reg_wdata[13:0] & IEN_MASK;
    end
  end

  logic [7:0] rx_cnt8, tx_cnt8;
  logic rx_rdy, tx_rdy;
  assign rx_cnt8 = 8'(cnt_w[0]);
  assign tx_cnt8 = 8'(cnt_w[1]);
  assign rx_rdy  = rx_cnt8 >= rx_trig_q;
  assign tx_rdy  = tx_cnt8 <= tx_trig_q;

  logic [6:0] lvl_q;
  logic [5:0] evt_q, evt_set, evt_clr;

  assign evt_set = {cs_inval, xfer_done,
                    tx_pop & empty_w[1], tx_push & full_w[1],
                    rx_pop & empty_w[0], rx_push & full_w[0]};
  assign evt_clr = wr_sta ? reg_wdata[13:8] : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 7'h22;
      evt_q <= '0;
    end else begin
      lvl_q <= {full_w[1], empty_w[1], tx_rdy, 1'b0, full_w[0], empty_w[0], rx_rdy};
      evt_q <= (evt_q & ~evt_clr) | evt_set;
    end
  end

  logic [31:0] status;
  assign status = {18'd0, evt_q, 1'b0, lvl_q};

  assign irq        = |(status[13:0] & ien_q);
  assign rx_dreq    = rx_dma_q & rx_rdy;
  assign tx_dreq    = tx_dma_q & tx_rdy;
  assign shift_hold = stop_en & full_w[0];

  always_comb begin
    unique case (reg_sel)
      2'd0: reg_rdata = {18'd0, ien_q};
      2'd1: reg_rdata = status;
      2'd2: reg_rdata = {7'd0, tx_dma_q, tx_trig_q, 7'd0, rx_dma_q, rx_trig_q};
      default: reg_rdata = {8'd0, tx_cnt8, 8'd0, rx_cnt8};
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[30:25], reg_wdata[14]};
endmodule

// File: rtl/fifo_irq_status_chk.sv
module fifo_irq_status_chk #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic          rx_push,
  input logic          irq,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [5:0]    evt_q,
  input logic [13:0]   ien_q
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH)); // R5

  AST_RX_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH)) |=> evt_q[0]); // R6

  AST_STICKY_RX_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[0] && !(reg_we && reg_sel == 2'd1 && reg_wdata[8])) |=> evt_q[0]); // R7

  AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2 && reg_wdata[15]) |=> rx_cnt == '0); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R9
endmodule

bind fifo_irq_status fifo_irq_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .rx_push(rx_push), .irq(irq),
  .rx_cnt(cnt_w[0]), .tx_cnt(cnt_w[1]), .evt_q(evt_q), .ien_q(ien_q));

// File: tb/tb_fifo_irq_status.sv
module tb_fifo_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
  logic xfer_done = 0, cs_inval = 0, stop_en = 0;
  logic shift_hold, irq, tx_dreq, rx_dreq;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  fifo_irq_status dut (.*);

  // rows: {rx_trig, tx_trig, fill, expected status[7:0]}
  localparam logic [31:0] TABLE [8] = '{
    32'h01_40_00_32, 32'h01_40_01_11, 32'h04_03_03_10, 32'h04_03_04_01,
    32'h80_7F_80_45, 32'h80_80_7F_10, 32'h00_00_00_33, 32'hFF_FF_05_10};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic push(input logic to_rx, input logic to_tx, input logic [7:0] d);
    rx_push = to_rx; tx_push = to_tx; rx_wdata = d; tx_wdata = d;
    @(negedge clk);
    rx_push = 0; tx_push = 0;
  endtask

  task automatic pop(input logic from_rx, input logic from_tx);
    rx_pop = from_rx; tx_pop = from_tx;
    @(negedge clk);
    rx_pop = 0; tx_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, s0;
    int bad;
    #12;
    rd(1, v); chk("R1 status", v, 32'h22);
    rd(2, v); chk("R1 ctrl", v, 32'h0040_0001);
    rd(0, v); chk("R1 enable", v, 0);
    rd(3, v); chk("R1 occupancy", v, 0);
    chk("R1 outputs", {irq, rx_dreq, tx_dreq}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(1, v); chk("R4 tx ready after reset", v, 32'h32);

    foreach (TABLE[r]) begin
      logic [7:0] rt, tt, fl, ex;
      {rt, tt, fl, ex} = TABLE[r];
      wr(2, {8'h80, tt, 8'h80, rt});
      for (int i = 0; i < int'(fl); i++) push(1, 1, 8'(i));
      @(negedge clk);
      rd(1, v); chk($sformatf("R3 R4 R5 row%0d status", r), v, {24'd0, ex});
      rd(3, v); chk($sformatf("R2 row%0d occupancy", r), v, {8'd0, fl, 8'd0, fl});
      rd(2, v); chk($sformatf("R10 row%0d ctrl readback", r), v, {8'd0, tt, 8'd0, rt});
    end

    // ordering and simultaneous push/pop
    wr(2, 32'h8040_8001);
    push(1, 1, 8'hA1); push(1, 1, 8'hA2); push(1, 1, 8'hA3);
    chk("R2 rx head", rx_rdata, 8'hA1);
    pop(1, 1);
    chk("R2 rx second", rx_rdata, 8'hA2);
    chk("R2 tx second", tx_rdata, 8'hA2);
    rx_push = 1; rx_pop = 1; rx_wdata = 8'hA4; @(negedge clk); rx_push = 0; rx_pop = 0;
    rd(3, v); chk("R2 push+pop keeps count", v, 32'h0002_0002);
    chk("R2 rx third", rx_rdata, 8'hA3);

    // receive overflow, hold, underrun
    wr(2, 32'h8040_8001);
    wr(1, 32'h3F00);
    for (int i = 0; i < 128; i++) push(1, 0, 8'(i));
    stop_en = 1; #1;
    chk("R12 hold when full", shift_hold, 1);
    push(1, 0, 8'h5A);
    rd(3, v); chk("R5 push while full dropped", v, 32'h0000_0080);
    rd(1, v); chk("R6 rx overflow bit8", v[8], 1);
    stop_en = 0; #1;
    chk("R12 no hold without stop_en", shift_hold, 0);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      if (rx_rdata !== 8'(i)) bad++;
      pop(1, 0);
    end
    chk("R2 order over full depth", bad, 0);
    pop(1, 0);
    rd(3, v); chk("R6 underrun leaves count", v, 0);
    rd(1, v); chk("R6 rx underrun bit9", v[9:8], 2'b11);

    // write-one-to-clear
    wr(1, 32'h0100);
    rd(1, v); chk("R7 clear bit8 only", v[9:8], 2'b10);
    wr(1, 32'h0);
    rd(1, v); chk("R7 zero write keeps bit9", v[9], 1);
    @(negedge clk);
    rd(1, s0);
    wr(1, 32'h00FF);
    rd(1, v); chk("R7 level bits not writable", v, s0);

    // transmit errors
    pop(0, 1);
    rd(1, v); chk("R6 tx underrun bit11", v[11], 1);
    for (int i = 0; i < 129; i++) push(0, 1, 8'(i));
    rd(3, v); chk("R5 tx capped at 128", v, 32'h0080_0000);
    rd(1, v); chk("R6 tx overflow bit10", v[10], 1);

    // events; set wins over same-cycle clear
    xfer_done = 1; wr(1, 32'h1000); xfer_done = 0;
    rd(1, v); chk("R7 R8 event beats clear bit12", v[12], 1);
    cs_inval = 1; @(negedge clk); cs_inval = 0;
    @(negedge clk);
    rd(1, v); chk("R8 full status word", v, 32'h3E42);

    // enables and interrupt
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R9 enable mask", v, 32'h3F77);
    chk("R9 irq all enabled", irq, 1);
    wr(1, 32'h3F00);
    wr(0, 32'h1000);
    chk("R9 irq low after clear", irq, 0);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    chk("R9 irq from event", irq, 1);
    wr(1, 32'h1000);
    chk("R9 irq cleared", irq, 0);
    wr(0, 32'h0040);
    chk("R9 irq from tx full level", irq, 1);
    wr(0, 32'h0);

    // flush one side only
    push(1, 0, 8'h11); push(1, 0, 8'h22);
    wr(2, 32'h0040_8001);
    rd(3, v); chk("R10 rx flush keeps tx", v, 32'h0080_0000);
    rd(2, v); chk("R10 reset bit reads 0", v, 32'h0040_0001);

    // DMA requests
    wr(2, 32'h8140_0102);
    chk("R11 dreq tx empty rx empty", {tx_dreq, rx_dreq}, 2'b10);
    push(1, 0, 8'h01);
    chk("R11 rx below trigger", rx_dreq, 0);
    push(1, 0, 8'h02);
    chk("R11 rx at trigger", rx_dreq, 1);
    wr(2, 32'h0100_0002);
    chk("R11 rx dma disabled", rx_dreq, 0);
    chk("R11 tx trig 0 empty", tx_dreq, 1);
    push(0, 1, 8'h03);
    chk("R11 tx above trigger", tx_dreq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule